// File: doc/BRIEF.md
# Clock Output Mode Controller

This block holds the control logic for a differential clock output stage. Two active-low control pins decide the operating state. When the power-down pin is low, the stage is off and both output pins are driven to ground. When the power-down pin is high and the stop pin is low, the output buffer is released to high impedance. When both pins are high, the stage drives the clock that the mode code has selected. The clock pairs themselves pass through combinational selection. The state, the captured mode code and the settle counters run on a local control clock.

A two-bit mode code picks which clock pair reaches the outputs. It can pick the phase-aligned pair, the raw PLL pair or the reference pair, or it can put both pins in high impedance for an output test. The code is captured only while the stage is powered down, and the captured value stays in effect until the next power-down. When power-down is released, a programmable count holds the pins low so that the source can settle. A change on the multiplier-select pins while running normally is a hot swap, and it raises a busy flag for a second programmable count. There is no data stream, so every pin is a plain level with no handshake.

Top module: `clkout_mode_ctrl`

## Requirements
- R1: While `pwrdn_n` is 0, `drive_low_p` and `drive_low_n` are 1, `hiz_p` and `hiz_n` are 0, and `out_p`/`out_n` are 0, whatever the value of `stop_n`.
- R2: While `pwrdn_n` is 1, `stop_n` is 0 and no exit hold is active, `hiz_p` and `hiz_n` are 1, `drive_low_p` and `drive_low_n` are 0, and both outputs are 0.
- R3: While running (both control pins 1, no exit hold) with captured mode 2'b00, `out_p` follows `pa_clk`, `out_n` follows `pa_clk_b`, and all four enables are 0.
- R4: While running with captured mode 2'b01, `out_p`/`out_n` follow `pll_clk`/`pll_clk_b`, and all enables are 0.
- R5: While running with captured mode 2'b11, `out_p`/`out_n` follow `ref_clk`/`ref_clk_b`, and all enables are 0.
- R6: While running with captured mode 2'b10 (bit 1 set, bit 0 clear), `hiz_p` and `hiz_n` are 1 and both outputs are 0.
- R7: `mode_sel` is captured on every control clock edge at which `pwrdn_n` is 0. A change on `mode_sel` while `pwrdn_n` is 1 has no effect. After reset the captured mode is 2'b00.
- R8: After `pwrdn_n` rises, the outputs are held low (drive_low both 1) through the first PD_SETTLE control clock edges that see `pwrdn_n` at 1, and they follow the state and mode after that. When reset is released with `pwrdn_n` at 1, the state follows the pins at once, with no hold.
- R9: A change on `mult_sel` seen at an edge while running sets `settle_busy` for the MULT_SETTLE cycles that follow. A change seen while the stop pin is low does not start this window.
- R10: `settle_busy` is 1 while `pwrdn_n` is 0 and during the exit hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down |
| stop_n | input | 1 | Active-low clock stop |
| mode_sel | input | 2 | Output mode code, captured in power-down |
| mult_sel | input | MULT_W | Multiplier select |
| pa_clk | input | 1 | Phase-aligned clock |
| pa_clk_b | input | 1 | Phase-aligned clock complement |
| pll_clk | input | 1 | Raw PLL clock |
| pll_clk_b | input | 1 | Raw PLL clock complement |
| ref_clk | input | 1 | Reference clock |
| ref_clk_b | input | 1 | Reference clock complement |
| out_p | output | 1 | True output |
| out_n | output | 1 | Complement output |
| drive_low_p | output | 1 | Ground enable, true pin |
| drive_low_n | output | 1 | Ground enable, complement pin |
| hiz_p | output | 1 | High-impedance enable, true pin |
| hiz_n | output | 1 | High-impedance enable, complement pin |
| settle_busy | output | 1 | Settling in progress |

## Verification
The hardest case to reach is the last edge of the exit hold. It is only visible after a full power-down round trip, and the mode code has to be set up while the stage is still down. Each table entry therefore goes through power-down, loads its mode, and releases power-down at a falling edge. The bench then counts exactly PD_SETTLE rising edges before it drives the clock pattern. The directed tests also sample one edge before the hold ends, and they drive a multiplier change while the stop pin is low. This confirms that the hot-swap window does not start in that state.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    MODE_ALIGNED = 2'b00,
    MODE_BYPASS  = 2'b01,
    MODE_HIZ     = 2'b10,
    MODE_REF     = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_EXIT  = 2'd1,
    ST_STOP  = 2'd2,
    ST_RUN   = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/clkout_state_fsm.sv
module clkout_state_fsm
  import clkout_pkg::*;
#(
  parameter int PD_SETTLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       stop_n,
  input  logic [1:0] mode_pin,
  output ctl_state_e state,
  output clk_mode_e  mode_q,
  output logic       exit_busy
);
  localparam int PW = $clog2(PD_SETTLE + 1);
  localparam logic [PW-1:0] PD_LOAD = PW'(PD_SETTLE);

  logic [PW-1:0] pd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ALIGNED;
      pd_cnt <= '0;
    end else if (!pwrdn_n) begin
      mode_q <= clk_mode_e'(mode_pin);
      pd_cnt <= PD_LOAD;
    end else if (pd_cnt != '0) begin
      pd_cnt <= pd_cnt - 1'b1;
    end
  end

  assign exit_busy = (pd_cnt != '0);

  always_comb begin
    if (!pwrdn_n)       state = ST_PWRDN;
    else if (exit_busy) state = ST_EXIT;
    else if (!stop_n)   state = ST_STOP;
    else                state = ST_RUN;
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_n |=> $stable(mode_q)); // R7
  AST_EXIT_ENDS_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exit_busy) |-> pwrdn_n); // R8
endmodule

// File: rtl/clkout_mult_watch.sv
module clkout_mult_watch #(
  parameter int MULT_SETTLE = 6,
  parameter int MULT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              pwrdn_n,
  input  logic [MULT_W-1:0] mult_pin,
  output logic              busy
);
  localparam int CW = $clog2(MULT_SETTLE + 1);
  localparam logic [CW-1:0] MS_LOAD = CW'(MULT_SETTLE);

  logic [MULT_W-1:0] mult_q;
  logic              seen;
  logic [CW-1:0]     cnt;
  logic              swap;

  assign swap = seen && (mult_pin != mult_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      seen   <= 1'b0;
      cnt    <= '0;
    end else begin
      mult_q <= mult_pin;
      seen   <= 1'b1;
      if (!pwrdn_n)               cnt <= '0;
      else if (swap && running)   cnt <= MS_LOAD;
      else if (cnt != '0)         cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  AST_HOT_SWAP_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(running)); // R9
endmodule

// File: rtl/clkout_out_mux.sv
module clkout_out_mux
  import clkout_pkg::*;
(
  input  ctl_state_e state,
  input  clk_mode_e  mode,
  input  logic       pa_clk,
  input  logic       pa_clk_b,
  input  logic       pll_clk,
  input  logic       pll_clk_b,
  input  logic       ref_clk,
  input  logic       ref_clk_b,
  output logic       out_p,
  output logic       out_n,
  output logic       drive_low_p,
  output logic       drive_low_n,
  output logic       hiz_p,
  output logic       hiz_n
);
  always_comb begin
    out_p = 1'b0; out_n = 1'b0;
    drive_low_p = 1'b0; drive_low_n = 1'b0;
    hiz_p = 1'b0; hiz_n = 1'b0;
    unique case (state)
      ST_PWRDN, ST_EXIT: begin
        drive_low_p = 1'b1; drive_low_n = 1'b1;
      end
      ST_STOP: begin
        hiz_p = 1'b1; hiz_n = 1'b1;
      end
      default: begin
        unique case (mode)
          MODE_ALIGNED: begin out_p = pa_clk;  out_n = pa_clk_b;  end
          MODE_BYPASS:  begin out_p = pll_clk; out_n = pll_clk_b; end
          MODE_REF:     begin out_p = ref_clk; out_n = ref_clk_b; end
          default:      begin hiz_p = 1'b1;    hiz_n = 1'b1;      end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/clkout_mode_ctrl.sv
module clkout_mode_ctrl
  import clkout_pkg::*;
#(
  parameter int PD_SETTLE   = 8,
  parameter int MULT_SETTLE = 6,
  parameter int MULT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn_n,
  input  logic              stop_n,
  input  logic [1:0]        mode_sel,
  input  logic [MULT_W-1:0] mult_sel,
  input  logic              pa_clk,
  input  logic              pa_clk_b,
  input  logic              pll_clk,
  input  logic              pll_clk_b,
  input  logic              ref_clk,
  input  logic              ref_clk_b,
  output logic              out_p,
  output logic              out_n,
  output logic              drive_low_p,
  output logic              drive_low_n,
  output logic              hiz_p,
  output logic              hiz_n,
  output logic              settle_busy
);
  ctl_state_e state;
  clk_mode_e  mode_q;
  logic       exit_busy;
  logic       mult_busy;

  clkout_state_fsm #(.PD_SETTLE(PD_SETTLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .stop_n(stop_n),
    .mode_pin(mode_sel), .state(state), .mode_q(mode_q), .exit_busy(exit_busy)
  );

  clkout_mult_watch #(.MULT_SETTLE(MULT_SETTLE), .MULT_W(MULT_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .running(state == ST_RUN), .pwrdn_n(pwrdn_n),
    .mult_pin(mult_sel), .busy(mult_busy)
  );

  clkout_out_mux u_mux (
    .state(state), .mode(mode_q),
    .pa_clk(pa_clk), .pa_clk_b(pa_clk_b),
    .pll_clk(pll_clk), .pll_clk_b(pll_clk_b),
    .ref_clk(ref_clk), .ref_clk_b(ref_clk_b),
    .out_p(out_p), .out_n(out_n),
    .drive_low_p(drive_low_p), .drive_low_n(drive_low_n),
    .hiz_p(hiz_p), .hiz_n(hiz_n)
  );

  assign settle_busy = exit_busy | mult_busy;

  AST_PD_GROUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> (drive_low_p && drive_low_n && !hiz_p && !hiz_n && !out_p && !out_n)); // R1
  AST_PIN_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_low_p, hiz_p}) && $onehot0({drive_low_n, hiz_n})); // R2
  AST_PD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> settle_busy); // R10
endmodule

// File: tb/clkout_mode_ctrl_bench.sv
module clkout_mode_ctrl_bench;
  localparam int PD = 8;
  localparam int MS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n = 1'b1, stop_n = 1'b1;
  logic [1:0] mode_sel = 2'b00, mult_sel = 2'b00;
  logic [5:0] clks = 6'b100101; // {pa, pa_b, pll, pll_b, ref, ref_b}
  logic out_p, out_n, drive_low_p, drive_low_n, hiz_p, hiz_n, settle_busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkout_mode_ctrl #(.PD_SETTLE(PD), .MULT_SETTLE(MS), .MULT_W(2)) u_clkout_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .stop_n(stop_n),
    .mode_sel(mode_sel), .mult_sel(mult_sel),
    .pa_clk(clks[5]), .pa_clk_b(clks[4]), .pll_clk(clks[3]), .pll_clk_b(clks[2]),
    .ref_clk(clks[1]), .ref_clk_b(clks[0]),
    .out_p(out_p), .out_n(out_n), .drive_low_p(drive_low_p), .drive_low_n(drive_low_n),
    .hiz_p(hiz_p), .hiz_n(hiz_n), .settle_busy(settle_busy)
  );

  wire [5:0] obs = {out_p, out_n, drive_low_p, drive_low_n, hiz_p, hiz_n};

  // {mode, clocks, expected {out_p,out_n,dl_p,dl_n,hz_p,hz_n}}
  localparam logic [13:0] VEC [8] = '{
    {2'b00, 6'b100101, 6'b100000},
    {2'b00, 6'b011010, 6'b010000},
    {2'b01, 6'b100110, 6'b010000},
    {2'b01, 6'b011001, 6'b100000},
    {2'b11, 6'b101001, 6'b010000},
    {2'b11, 6'b010110, 6'b100000},
    {2'b10, 6'b111111, 6'b000011},
    {2'b10, 6'b000000, 6'b000011}
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic enter_mode(input logic [1:0] m);
    @(negedge clk);
    pwrdn_n = 1'b0; mode_sel = m;
    @(posedge clk);
    @(negedge clk);
    pwrdn_n = 1'b1;
    repeat (PD) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 reset no hold, R3 aligned route", obs, 6'b100000);
    chk("R9 busy clear after reset", {5'b0, settle_busy}, 6'b0);

    for (int i = 0; i < 8; i++) begin
      enter_mode(VEC[i][13:12]);
      clks = VEC[i][11:6];
      #1;
      chk($sformatf("R3 R4 R5 R6 table entry %0d", i), obs, VEC[i][5:0]);
    end

    // R7: mode pins ignored while powered
    enter_mode(2'b00);
    clks = 6'b100101;
    mode_sel = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 mode change while running ignored", obs, 6'b100000);

    // R2 clock stop, and R9 no window in stop
    stop_n = 1'b0;
    #1;
    chk("R2 clock stop high impedance", obs, 6'b000011);
    mult_sel = 2'b01;
    @(posedge clk); @(negedge clk);
    chk("R9 multiplier change in stop no busy", {5'b0, settle_busy}, 6'b0);
    stop_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 leaving stop no busy", {5'b0, settle_busy}, 6'b0);

    // R9 hot swap window
    mult_sel = 2'b10;
    @(posedge clk); @(negedge clk);
    chk("R9 hot swap busy first cycle", {5'b0, settle_busy}, 6'b1);
    repeat (MS - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 hot swap busy last cycle", {5'b0, settle_busy}, 6'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 hot swap busy cleared", {5'b0, settle_busy}, 6'b0);
    chk("R3 outputs unaffected by hot swap", obs, 6'b100000);

    // R1 power-down regardless of stop, R10 busy
    pwrdn_n = 1'b0; stop_n = 1'b0;
    #1;
    chk("R1 power-down with stop low", obs, 6'b001100);
    stop_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 power-down with stop high", obs, 6'b001100);
    chk("R10 busy in power-down", {5'b0, settle_busy}, 6'b1);

    // R8 exit hold boundary (mode_sel 11 captured)
    clks = 6'b101001;
    pwrdn_n = 1'b1;
    #1;
    chk("R8 hold right after power-up", obs, 6'b001100);
    repeat (PD - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 hold last cycle", obs, 6'b001100);
    chk("R10 busy during exit hold", {5'b0, settle_busy}, 6'b1);
    @(posedge clk); @(negedge clk);
    chk("R8 released R5 reference route", obs, 6'b010000);
    chk("R10 busy clears after hold", {5'b0, settle_busy}, 6'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule